// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder/Subtractor

This block adds or subtracts two N-digit radix-2 signed-digit numbers whose digits take the values -1, 0 and +1. Each digit travels on a pair of wires, one wire flagging a negative digit and one flagging a positive digit. The sum has N+1 digits and uses the same encoding. The carry chain of a conventional adder is absent. Each digit position looks only at its own two operand digits, plus a transfer digit and a one-bit hint from the position just below it. For that reason the logic depth stays fixed as N grows.

The hint from a position is raised whenever either of its operand digits is -1. A position whose inputs are critical uses the hint to pick between its two legal ways of splitting the operand sum into an outgoing transfer and a local remainder. A position is critical when one of its operand digits is zero and the other is not. With that choice made from the hint, the final sum digit never leaves the legal range. When the subtract control is set, the second operand is negated by exchanging its two wires in every position. The operands and the control are captured in an input register stage and the sum in an output register stage, so a result appears two clock edges after its operands.

Top module: `sd_adder`

## Requirements
- R1: Each digit is the pair (neg, pos): -1 is (1,0), 0 is (0,0), +1 is (0,1). The block never produces (1,1) on any output digit.
- R2: With `sub_i` = 0, the value of the (N+1)-digit output equals the value of `a` plus the value of `b`. Digit i has weight 2^i.
- R3: With `sub_i` = 1, the value of the output equals the value of `a` minus the value of `b`.
- R4: The output reflects the operands and `sub_i` present at a rising clock edge from the second rising edge onward. After the first edge it still shows the previous result. While `rst_n` is low, every output wire is 0.
- R5: The hint passed from position i to i+1 is set exactly when an operand digit of position i is -1. An outgoing transfer of +1 is always paired with a clear hint, and a transfer of -1 with a set hint.
- R6: Output digit N equals the transfer out of the top position, so extreme operands produce a nonzero digit N. For example, all digits +1 plus all digits +1 gives 2^(N+1)-2.
- R7: When both operands are zero, every output digit is 0. Zero has only the all-zero representation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_i | input | 1 | 1 selects a minus b, 0 selects a plus b |
| a_neg | input | N | Negative wire of each digit of operand a |
| a_pos | input | N | Positive wire of each digit of operand a |
| b_neg | input | N | Negative wire of each digit of operand b |
| b_pos | input | N | Positive wire of each digit of operand b |
| s_neg | output | N+1 | Negative wire of each sum digit |
| s_pos | output | N+1 | Positive wire of each sum digit |

## Verification
The checks assume that no operand digit is ever driven as (1,1). That code has no meaning, and the flag-pairing argument that keeps sum digits legal depends on its absence. The checker states this assumption as its own property on the input ports. The stimulus builds every operand digit by picking one of the three legal codes, both in random draws and in the directed patterns: extremes, alternating signs, isolated critical positions and zero. The arithmetic properties compare decoded integers only once two clock edges have passed since reset, so the register stages hold real operands before anything is compared.

// File: rtl/sd_adder.sv
module sd_adder #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sub_i,
  input  logic [N-1:0] a_neg,
  input  logic [N-1:0] a_pos,
  input  logic [N-1:0] b_neg,
  input  logic [N-1:0] b_pos,
  output logic [N:0]   s_neg,
  output logic [N:0]   s_pos
);
  logic [N-1:0] ra_n, ra_p, rb_n, rb_p;
  logic         rsub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_n <= '0; ra_p <= '0; rb_n <= '0; rb_p <= '0; rsub <= 1'b0;
    end else begin
      ra_n <= a_neg; ra_p <= a_pos; rb_n <= b_neg; rb_p <= b_pos; rsub <= sub_i;
    end
  end

  logic [N-1:0] bn, bp;
  assign bn = rsub ? rb_p : rb_n;
  assign bp = rsub ? rb_n : rb_p;

  logic [N-1:0] za, zb, crit, hint_out, hint_in;
  logic [N-1:0] t_neg, t_pos, tin_n, tin_p, up, dn, d_n, d_p;

  assign za       = ~ra_n & ~ra_p;
  assign zb       = ~bn & ~bp;
  assign crit     = za ^ zb;
  assign hint_out = ra_n | bn;
  assign hint_in  = {hint_out[N-2:0], 1'b0};

  assign t_neg = (ra_n & bn) | (crit & (ra_n | bn) & hint_in);
  assign t_pos = (ra_p & bp) | (crit & (ra_p | bp) & ~hint_in);

  assign tin_n = {t_neg[N-2:0], 1'b0};
  assign tin_p = {t_pos[N-2:0], 1'b0};

  assign up  = crit & hint_in;
  assign dn  = crit & ~hint_in;
  assign d_n = (dn & ~tin_p) | (~dn & ~up & tin_n);
  assign d_p = (up & ~tin_n) | (~up & ~dn & tin_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_neg <= '0;
      s_pos <= '0;
    end else begin
      s_neg <= {t_neg[N-1], d_n};
      s_pos <= {t_pos[N-1], d_p};
    end
  end
endmodule

// File: rtl/sd_adder_chk.sv
module sd_adder_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sub_i,
  input logic [N-1:0] a_neg,
  input logic [N-1:0] a_pos,
  input logic [N-1:0] b_neg,
  input logic [N-1:0] b_pos,
  input logic [N:0]   s_neg,
  input logic [N:0]   s_pos,
  input logic [N-1:0] t_neg,
  input logic [N-1:0] t_pos,
  input logic [N-1:0] hint_out
);
  function automatic longint val(input logic [N:0] n, input logic [N:0] p);
    longint v = 0;
    for (int i = N; i >= 0; i--) v = 2 * v + longint'(p[i]) - longint'(n[i]);
    return v;
  endfunction

  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 2'd0;
    else if (edges != 2'd3) edges <= edges + 2'd1;
  end

  p_legal_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_neg & a_pos) == '0) && ((b_neg & b_pos) == '0));

  p_legal_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_neg & s_pos) == '0);

  p_sum_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2 && !$past(sub_i, 2)) |->
      val(s_neg, s_pos) == val({1'b0, $past(a_neg, 2)}, {1'b0, $past(a_pos, 2)})
                         + val({1'b0, $past(b_neg, 2)}, {1'b0, $past(b_pos, 2)}));

  p_diff_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2 && $past(sub_i, 2)) |->
      val(s_neg, s_pos) == val({1'b0, $past(a_neg, 2)}, {1'b0, $past(a_pos, 2)})
                         - val({1'b0, $past(b_neg, 2)}, {1'b0, $past(b_pos, 2)}));

  p_flag_pairing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((t_pos & hint_out) == '0) && ((t_neg & ~hint_out) == '0));

  p_top_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd1) |-> (s_neg[N] == $past(t_neg[N-1]) && s_pos[N] == $past(t_pos[N-1])));

  p_zero_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2 && $past(a_neg | a_pos | b_neg | b_pos, 2) == '0) |->
      (s_neg == '0 && s_pos == '0));
endmodule

bind sd_adder sd_adder_chk #(.N(N)) i_chk (
  .clk(clk), .rst_n(rst_n), .sub_i(sub_i),
  .a_neg(a_neg), .a_pos(a_pos), .b_neg(b_neg), .b_pos(b_pos),
  .s_neg(s_neg), .s_pos(s_pos),
  .t_neg(t_neg), .t_pos(t_pos), .hint_out(hint_out)
);

// File: tb/test_sd_adder.sv
module test_sd_adder;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sub_i = 1'b0;
  logic [N-1:0] a_neg = '0, a_pos = '0, b_neg = '0, b_pos = '0;
  logic [N:0]   s_neg, s_pos;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sd_adder #(.N(N)) i_sd_adder (
    .clk(clk), .rst_n(rst_n), .sub_i(sub_i),
    .a_neg(a_neg), .a_pos(a_pos), .b_neg(b_neg), .b_pos(b_pos),
    .s_neg(s_neg), .s_pos(s_pos)
  );

  function automatic longint dec(input logic [N:0] n, input logic [N:0] p);
    longint v = 0;
    for (int i = N; i >= 0; i--) v = 2 * v + longint'(p[i]) - longint'(n[i]);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] an, ap, bn, bp, input logic sb);
    @(negedge clk);
    a_neg = an; a_pos = ap; b_neg = bn; b_pos = bp; sub_i = sb;
  endtask

  task automatic run(input logic [N-1:0] an, ap, bn, bp, input logic sb, input string req);
    longint ea, eb, ex;
    drive(an, ap, bn, bp, sb);
    @(posedge clk); @(posedge clk); @(negedge clk);
    ea = dec({1'b0, an}, {1'b0, ap});
    eb = dec({1'b0, bn}, {1'b0, bp});
    ex = sb ? ea - eb : ea + eb;
    check(dec(s_neg, s_pos) == ex, req, dec(s_neg, s_pos), ex);
    check((s_neg & s_pos) == '0, "R1", longint'(s_neg & s_pos), 0);
  endtask

  task automatic rand_digits(output logic [N-1:0] n, output logic [N-1:0] p);
    for (int i = 0; i < N; i++) begin
      int k = $urandom_range(0, 2);
      n[i] = (k == 0);
      p[i] = (k == 2);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive({N{1'b0}}, {N{1'b1}}, {N{1'b0}}, {N{1'b1}}, 1'b0);
    @(posedge clk); @(negedge clk);
    check(s_neg == '0 && s_pos == '0, "R4 reset", dec(s_neg, s_pos), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_random_add;
    logic [N-1:0] an, ap, bn, bp;
    for (int r = 0; r < 200; r++) begin
      rand_digits(an, ap); rand_digits(bn, bp);
      run(an, ap, bn, bp, 1'b0, "R2 random add");
    end
  endtask

  task automatic t_random_sub;
    logic [N-1:0] an, ap, bn, bp;
    for (int r = 0; r < 200; r++) begin
      rand_digits(an, ap); rand_digits(bn, bp);
      run(an, ap, bn, bp, 1'b1, "R3 random sub");
    end
  endtask

  task automatic t_extremes;
    longint top;
    run('0, '1, '0, '1, 1'b0, "R6 max plus max");
    top = 2 ** (N + 1) - 2;
    check(s_pos[N] == 1'b1 && s_neg[N] == 1'b0, "R6 top digit +1", dec(s_neg, s_pos), top);
    run('1, '0, '1, '0, 1'b0, "R6 min plus min");
    check(s_neg[N] == 1'b1 && s_pos[N] == 1'b0, "R6 top digit -1", dec(s_neg, s_pos), -top);
    run('0, '1, '1, '0, 1'b1, "R3 max minus min");
    run('1, '0, '0, '1, 1'b1, "R3 min minus max");
  endtask

  task automatic t_critical;
    logic [N-1:0] alt = {(N/2){2'b01}};
    run(alt, ~alt, '0, '0, 1'b0, "R5 alternating plus zero");
    run('0, '1, '0, '0, 1'b0, "R5 all +1 plus zero");
    run('1, '0, '0, '0, 1'b0, "R5 all -1 plus zero");
    run('0, '1, '1, '0, 1'b0, "R5 cancelling digits");
    run(16'h00F0, 16'h0F00, 16'h0F00, 16'h00F0, 1'b0, "R5 mixed critical blocks");
    run('0, 16'h0001, '0, 16'h0001, 1'b0, "R2 single carry");
    run(16'h0001, '0, '0, 16'h0001, 1'b1, "R3 negative one minus one");
  endtask

  task automatic t_zero;
    run('0, '0, '0, '0, 1'b0, "R7 zero plus zero");
    check(s_neg == '0 && s_pos == '0, "R7 all digits zero", dec(s_neg, s_pos), 0);
    run('0, '0, '0, '0, 1'b1, "R7 zero minus zero");
    check(s_neg == '0 && s_pos == '0, "R7 all digits zero sub", dec(s_neg, s_pos), 0);
  endtask

  task automatic t_latency;
    run('0, 16'h0003, '0, 16'h0004, 1'b0, "R4 first result");
    drive('0, 16'h0010, '0, 16'h0020, 1'b0);
    @(posedge clk); @(negedge clk);
    check(dec(s_neg, s_pos) == 7, "R4 hold after one edge", dec(s_neg, s_pos), 7);
    @(posedge clk); @(negedge clk);
    check(dec(s_neg, s_pos) == 48, "R4 after two edges", dec(s_neg, s_pos), 48);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_zero();
    t_extremes();
    t_critical();
    t_random_add();
    t_random_sub();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule